// File: doc/BRIEF.md
# Subcode Shift Clock and Serial Deserializer

This block sits between a disc servo/decoder DSP and the text-data logic that follows it. For every subcode frame the DSP shifts out one byte, P first and W last. The block captures that byte and hands the low six bits (channels R through W) downstream as a symbol, with a one-cycle strobe.

The shift clock can come from either side. When `ext_sel` is low, the block makes the shift clock itself. After each frame-sync rising edge it waits a fixed number of master-clock cycles and then drives out eight pulses. The wait and the widths of the high and low phases depend on `dbl_speed`. When `ext_sel` is high, another device makes the shift clock. The block then synchronises that clock into the master-clock domain and takes one bit on each rising edge. In both modes, the block-sync level seen at the frame-sync edge travels with the symbol as a first-frame-of-block marker.

The frame-sync, block-sync, external shift clock and external-mode data inputs pass through two-stage synchronisers. All timing below is counted from the first master-clock edge that samples frame sync high.

Top module: `subcode_deser`

## Requirements
- R1: While `rst_n` is low and after its release, until a frame is received, `sclk_out`, `sym_valid`, `sym_data` and `sym_first` are all 0.
- R2: With `ext_sel` low, `sclk_oe` is 1 and the block drives the shift clock. With `ext_sel` high, `sclk_oe` is 0 and `sclk_out` stays low.
- R3: With `ext_sel` low and `dbl_speed` high, `sclk_out` first rises 208 master cycles after the first clock edge that samples `fsync` high. Every high phase and every low phase between pulses lasts 32 master cycles.
- R4: With `ext_sel` low and `dbl_speed` low, the first rise comes after 320 cycles, and every high and low phase lasts 128 cycles.
- R5: In drive mode, each frame-sync rising edge produces exactly eight `sclk_out` pulses. `sclk_out` then stays low until the next frame-sync edge.
- R6: Serial bits arrive in the order P, Q, R, S, T, U, V, W. In drive mode each bit is taken from `sdata` on the master edge at which `sclk_out` rises. The symbol carries R in `sym_data[5]` down to W in `sym_data[0]`, so a frame byte sent most-significant bit first yields its low six bits.
- R7: With `ext_sel` high, each rising edge of `sclk_in` shifts in one bit of `sdata`. The `sdata` value used is the one present when the rising edge is first sampled, and `sdata` must not change while `sclk_in` is high.
- R8: `sym_valid` is high for exactly one cycle once the eighth bit of a frame has been captured. Further shift edges before the next frame-sync edge are ignored and produce no strobe.
- R9: `sym_first` goes out with each strobe. It equals the `bsync` level present when the frame-sync edge was taken.
- R10: A frame-sync rising edge restarts the bit count. Bits of an unfinished frame are dropped, and the following eight bits form the next symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sel | input | 1 | 0: block drives shift clock, 1: shift clock is received |
| dbl_speed | input | 1 | 1: double-speed timing, 0: normal-speed timing |
| fsync | input | 1 | Frame sync, rising edge starts a frame |
| bsync | input | 1 | Block sync level |
| sdata | input | 1 | Serial subcode data |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Output enable for the shift clock pad |
| sym_valid | output | 1 | One-cycle symbol strobe |
| sym_data | output | 6 | R..W symbol, R in bit 5 |
| sym_first | output | 1 | Frame was flagged by block sync |

## Verification
The assertions take several things as given. `ext_sel` and `dbl_speed` stay fixed across a frame. Frame-sync edges are spaced wider than one full burst of shift pulses. In receive mode each phase of the external shift clock spans at least a few master cycles. The stimulus changes mode only while the block is idle between frames, and it starts a new frame only after the previous burst has finished plus a margin. External clock phases are drawn from 3 to 8 master cycles, and the data line changes only while the external clock is low.

// File: rtl/subcode_deser.sv
module subcode_deser #(
  parameter int DLY_DBL  = 208,
  parameter int HALF_DBL = 32,
  parameter int DLY_NRM  = 320,
  parameter int HALF_NRM = 128,
  parameter int BITS     = 8,
  parameter int SYM_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic             dbl_speed,
  input  logic             fsync,
  input  logic             bsync,
  input  logic             sdata,
  input  logic             sclk_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  output logic             sym_valid,
  output logic [SYM_W-1:0] sym_data,
  output logic             sym_first
);
  localparam int MAXD = (DLY_NRM > DLY_DBL) ? DLY_NRM : DLY_DBL;
  localparam int MAXH = (HALF_NRM > HALF_DBL) ? HALF_NRM : HALF_DBL;
  localparam int MAXC = (MAXD > MAXH) ? MAXD : MAXH;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BCW  = $clog2(BITS + 1);

  logic [2:0] fs_q, sc_q;
  logic [1:0] bs_q, sd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs_q <= '0; sc_q <= '0; bs_q <= '0; sd_q <= '0;
    end else begin
      fs_q <= {fs_q[1:0], fsync};
      sc_q <= {sc_q[1:0], sclk_in};
      bs_q <= {bs_q[0], bsync};
      sd_q <= {sd_q[0], sdata};
    end

  wire fs_rise = fs_q[1] & ~fs_q[2];
  wire sc_rise = sc_q[1] & ~sc_q[2];

  wire [CW-1:0] dly_ld  = dbl_speed ? CW'(DLY_DBL - 3)  : CW'(DLY_NRM - 3);
  wire [CW-1:0] half_ld = dbl_speed ? CW'(HALF_DBL - 1) : CW'(HALF_NRM - 1);

  logic          run, sclk_r;
  logic [CW-1:0] cnt;
  logic [BCW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= 1'b0; sclk_r <= 1'b0; cnt <= '0; pcnt <= '0;
    end else if (ext_sel) begin
      run <= 1'b0; sclk_r <= 1'b0;
    end else if (fs_rise) begin
      run <= 1'b1; sclk_r <= 1'b0; cnt <= dly_ld; pcnt <= '0;
    end else if (run) begin
      if (cnt == '0) begin
        sclk_r <= ~sclk_r;
        cnt    <= half_ld;
        if (sclk_r) begin
          pcnt <= pcnt + 1'b1;
          if (pcnt == BCW'(BITS - 1)) run <= 1'b0;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end

  wire gen_rise   = ~ext_sel & run & (cnt == '0) & ~sclk_r;
  wire shift_take = ext_sel ? sc_rise : gen_rise;
  wire shift_bit  = ext_sel ? sd_q[1] : sdata;

  assign sclk_out = sclk_r;
  assign sclk_oe  = ~ext_sel;

  logic [SYM_W-2:0] sh;
  logic [BCW-1:0]   bcnt;
  logic             blk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '0; bcnt <= BCW'(BITS); blk <= 1'b0;
      sym_valid <= 1'b0; sym_data <= '0; sym_first <= 1'b0;
    end else begin
      sym_valid <= 1'b0;
      if (fs_rise) begin
        bcnt <= '0;
        blk  <= bs_q[1];
      end else if (shift_take && bcnt != BCW'(BITS)) begin
        sh   <= {sh[SYM_W-3:0], shift_bit};
        bcnt <= bcnt + 1'b1;
        if (bcnt == BCW'(BITS - 1)) begin
          sym_valid <= 1'b1;
          sym_data  <= {sh, shift_bit};
          sym_first <= blk;
        end
      end
    end
endmodule

// File: rtl/subcode_deser_chk.sv
module subcode_deser_chk #(
  parameter int HALF_DBL = 32,
  parameter int HALF_NRM = 128,
  parameter int BITS     = 8,
  parameter int SYM_W    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_sel,
  input logic             dbl_speed,
  input logic             fs_rise,
  input logic             sclk_out,
  input logic             sym_valid,
  input logic [SYM_W-1:0] sym_data
);
  logic [15:0] hcnt;
  logic [7:0]  pc;
  logic        prev_o;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hcnt <= '0; pc <= '0; prev_o <= 1'b0;
    end else begin
      hcnt   <= sclk_out ? hcnt + 16'd1 : 16'd0;
      prev_o <= sclk_out;
      if (fs_rise) pc <= '0;
      else if (sclk_out && !prev_o) pc <= pc + 8'd1;
    end

  // R2
  ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel && $past(ext_sel) |-> !sclk_out);

  // R3 R4
  high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_out) |-> hcnt == (dbl_speed ? 16'(HALF_DBL) : 16'(HALF_NRM)));

  // R5
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_out) |-> pc < 8'(BITS));

  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |-> $stable(sym_data));
endmodule

bind subcode_deser subcode_deser_chk #(
  .HALF_DBL(HALF_DBL), .HALF_NRM(HALF_NRM), .BITS(BITS), .SYM_W(SYM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .dbl_speed(dbl_speed),
  .fs_rise(fs_rise), .sclk_out(sclk_out), .sym_valid(sym_valid),
  .sym_data(sym_data)
);

// File: tb/test_subcode_deser.sv
module test_subcode_deser;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_sel = 1'b0, dbl_speed = 1'b1, fsync = 1'b0, bsync = 1'b0;
  logic sdata = 1'b0, sclk_in = 1'b0;
  logic sclk_out, sclk_oe, sym_valid, sym_first;
  logic [5:0] sym_data;

  always #2 clk = ~clk;

  subcode_deser i_subcode_deser (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .dbl_speed(dbl_speed),
    .fsync(fsync), .bsync(bsync), .sdata(sdata), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sym_valid(sym_valid),
    .sym_data(sym_data), .sym_first(sym_first)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  int vcnt, rises, hrun, lrun, width_bad, t_first, exp_half;
  logic [5:0] vdata;
  logic vfirst, prev_o = 1'b0, any_hi;
  logic [7:0] cur_byte;
  int idx = 8;
  logic prev_d = 1'b0;

  always @(negedge clk) begin
    if (sym_valid) begin vcnt++; vdata = sym_data; vfirst = sym_first; end
    if (sclk_out && !prev_o) begin
      rises++;
      if (rises == 1) t_first = cyc;
      else if (lrun != exp_half) width_bad++;
      hrun = 0;
    end
    if (!sclk_out && prev_o) begin
      if (hrun != exp_half) width_bad++;
      lrun = 0;
    end
    if (sclk_out) begin hrun++; any_hi = 1'b1; end else lrun++;
    prev_o = sclk_out;
  end

  always @(negedge clk) begin
    if (!ext_sel) begin
      if (prev_d && !sclk_out && idx < 8) idx++;
      if (idx < 8) sdata = cur_byte[7 - idx];
    end
    prev_d = sclk_out;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dly_of(input logic dbl);
    return dbl ? 208 : 320;
  endfunction
  function automatic int half_of(input logic dbl);
    return dbl ? 32 : 128;
  endfunction

  task automatic clear_mon();
    vcnt = 0; rises = 0; hrun = 0; lrun = 0; width_bad = 0; t_first = -1;
    any_hi = 1'b0;
  endtask

  task automatic drive_frame(input logic dbl, input logic [7:0] b, input logic blk);
    int c0, d, h;
    string rq;
    @(negedge clk);
    dbl_speed = dbl; exp_half = half_of(dbl);
    d = dly_of(dbl); h = half_of(dbl);
    rq = dbl ? "R3" : "R4";
    clear_mon();
    cur_byte = b; idx = 0; sdata = b[7];
    fsync = 1'b1; bsync = blk; c0 = cyc;
    repeat (10) @(negedge clk);
    fsync = 1'b0; bsync = 1'b0;
    while (cyc < c0 + d + 16 * h + 40) @(negedge clk);
    chk(t_first - c0 == d + 1, {rq, " first rise delay"}, t_first - c0, d + 1);
    chk(width_bad == 0, {rq, " phase widths"}, width_bad, 0);
    chk(rises == 8, "R5 pulse count", rises, 8);
    chk(sclk_oe == 1'b1, "R2 drive enable", int'(sclk_oe), 1);
    chk(vcnt == 1, "R8 strobe count", vcnt, 1);
    chk(vdata == b[5:0], "R6 symbol", int'(vdata), int'(b[5:0]));
    chk(vfirst == blk, "R9 block marker", int'(vfirst), int'(blk));
  endtask

  task automatic ext_pulse(input logic bitv);
    int lo, hi;
    lo = 3 + int'($urandom % 6); hi = 3 + int'($urandom % 6);
    sdata = bitv;
    repeat (lo) @(negedge clk);
    sclk_in = 1'b1;
    repeat (hi) @(negedge clk);
    sclk_in = 1'b0;
  endtask

  task automatic ext_sync(input logic blk);
    fsync = 1'b1; bsync = blk;
    repeat (6) @(negedge clk);
    fsync = 1'b0; bsync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic ext_frame(input logic [7:0] b, input logic blk, input int pre, input int extra);
    logic [7:0] junk;
    @(negedge clk);
    clear_mon();
    junk = 8'($urandom);
    if (pre > 0) begin
      ext_sync(1'b0);
      for (int i = 0; i < pre; i++) ext_pulse(junk[7 - i]);
    end
    ext_sync(blk);
    for (int i = 0; i < 8; i++) ext_pulse(b[7 - i]);
    for (int i = 0; i < extra; i++) ext_pulse(junk[i % 8]);
    repeat (10) @(negedge clk);
    chk(vcnt == 1, "R8 strobe count (R7 input mode)", vcnt, 1);
    chk(vdata == b[5:0], pre > 0 ? "R10 restart symbol" : "R7 symbol",
        int'(vdata), int'(b[5:0]));
    chk(vfirst == blk, "R9 block marker", int'(vfirst), int'(blk));
    chk(!any_hi && sclk_oe == 1'b0, "R2 receive mode quiet", int'(any_hi), 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: actual %0d cycles expected completion earlier", cyc);
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    exp_half = 32;
    clear_mon();
    repeat (3) @(negedge clk);
    chk(sclk_out == 1'b0 && sym_valid == 1'b0, "R1 reset outputs", int'(sclk_out), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sym_data == 6'd0 && sym_first == 1'b0, "R1 idle symbol", int'(sym_data), 0);
    chk(sym_valid == 1'b0 && sclk_out == 1'b0, "R1 idle strobe", int'(sym_valid), 0);
    chk(sclk_oe == 1'b1, "R2 enable after reset", int'(sclk_oe), 1);

    drive_frame(1'b1, 8'hFF, 1'b1);
    drive_frame(1'b1, 8'h00, 1'b0);
    drive_frame(1'b1, 8'hA6, 1'b0);
    for (int i = 0; i < 3; i++) drive_frame(1'b1, 8'($urandom), 1'($urandom));
    drive_frame(1'b0, 8'h5A, 1'b1);
    drive_frame(1'b0, 8'($urandom), 1'($urandom));

    @(negedge clk); ext_sel = 1'b1;
    repeat (5) @(negedge clk);
    ext_frame(8'h3C, 1'b1, 0, 0);
    ext_frame(8'hC3, 1'b0, 0, 3);
    ext_frame(8'h81, 1'b0, 5, 0);
    for (int i = 0; i < 5; i++)
      ext_frame(8'($urandom), 1'($urandom), int'($urandom % 8), int'($urandom % 4));

    @(negedge clk); ext_sel = 1'b0;
    repeat (5) @(negedge clk);
    drive_frame(1'b1, 8'($urandom), 1'b1);
    finish_run();
  end
endmodule